// File: doc/BRIEF.md
# Split-Lane Big-Endian Memory Unit

This block is the memory unit of a 24-bit physical address bus with a 16-bit data bus. Storage is split into byte-wide banks: every even byte address lives in an even bank and every odd byte address in an odd bank. A fixed table of four lane enables moves the bytes between these banks and the two halves of the data bus. The even byte of a word always travels on the high half (big-endian). A byte read returns the addressed byte on the low half, with zeros above it.

The address space is decoded into a RAM region, a ROM-shadow region and everything else. The unit ignores everything else, which includes the device window. RAM is two even/odd bank pairs chosen by one address bit. Address bits that neither index a bank nor choose the pair are ignored, so higher RAM addresses alias onto the populated storage. The ROM shadow is one more even/odd pair. The bus can only read it. A separate loader port fills it one byte at a time, and a reset-time copy engine uses that port. Read data comes from registers one clock after the read strobe. Writes commit on the clock edge at which the write strobe is high.

Top module: `split_lane_mem`

## Requirements
- R1: An address with bit 23 low selects RAM; a read there raises `rvalid` one cycle later with the stored data.
- R2: An address with bit 23 high and bits 22..17 all zero selects the ROM shadow; a read there raises `rvalid` one cycle later.
- R3: Any other address (0x820000 and upward) gets no response: `rvalid` stays low, `rdata` is zero, and a write there changes no stored byte.
- R4: A word read (`is_byte`=0) returns the even-bank byte on `rdata[15:8]` and the odd-bank byte on `rdata[7:0]`.
- R5: A byte read (`is_byte`=1) returns the addressed byte on `rdata[7:0]` and zero on `rdata[15:8]`. Address bit 0 low reads the even bank; bit 0 high reads the odd bank.
- R6: A word write stores `wdata[15:8]` in the even bank and `wdata[7:0]` in the odd bank. A byte write stores `wdata[7:0]` in the bank picked by bit 0 only, and leaves the other bank's byte unchanged.
- R7: In RAM, bit 20 picks the bank pair and bits 8..1 index the bank (default depth). All other RAM address bits are ignored, so those addresses alias.
- R8: A word access at an odd address is neither flagged nor realigned. It behaves exactly like a word access at the address one lower.
- R9: `rvalid` is high only in the cycle after an accepted read. While `rvalid` is low, `rdata` is zero.
- R10: Bus writes to the ROM-shadow region are ignored.
- R11: A loader write (`ld_we`) stores `ld_data` in the ROM bank picked by `ld_addr[0]` (0 = even) at index `ld_addr[8:1]`. A bus read at 0x800000 + `ld_addr` returns that byte.
- R12: When a bus read and a loader write hit the same ROM location in the same cycle, the read returns the old byte, and the next read returns the new byte.
- R13: After reset, `rvalid` is low and `rdata` is zero. Stored bytes are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 24 | Physical byte address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| is_byte | input | 1 | 1 = byte access, 0 = word access |
| wdata | input | 16 | Write data from the bus |
| rdata | output | 16 | Read data, valid with rvalid |
| rvalid | output | 1 | Unit is driving read data this cycle |
| ld_we | input | 1 | Loader write strobe for the ROM shadow |
| ld_addr | input | 17 | Loader byte offset inside the ROM region |
| ld_data | input | 8 | Loader byte |

## Verification
The loader port and the bus read path share the ROM-shadow banks, so a loader write can land in the same cycle as a bus read of the same byte. The bench provokes this in a directed case and also at random during ROM reads. It takes the pre-write model value as the expected read result, and only afterwards applies the loader byte to its model. A later read then has to show the new byte, so a design that forwards the new write, or drops it, is caught.

// File: rtl/mu_pkg.sv
package mu_pkg;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_RAM  = 2'd1,
    REG_ROM  = 2'd2
  } region_e;

  // Four byte-lane paths between the even/odd banks and the data bus.
  typedef struct packed {
    logic ev_hi;  // even bank <-> bus[15:8]
    logic od_lo;  // odd bank  <-> bus[7:0]
    logic ev_lo;  // even bank <-> bus[7:0]
    logic zr_hi;  // zero      ->  bus[15:8] (reads only)
  } lanes_t;

endpackage

// File: rtl/mu_decode.sv
module mu_decode
  import mu_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int RAM_IDX_W = 8,
  parameter int ROM_IDX_W = 8,
  parameter int PAIR_BIT  = 20,
  parameter int ROM_TAG_LO = 17
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 is_byte,
  output region_e              region,
  output lanes_t               lanes,
  output logic                 pair,
  output logic [RAM_IDX_W-1:0] ram_idx,
  output logic [ROM_IDX_W-1:0] rom_idx
);

  logic rom_tag_zero;
  logic addr_unused;

  assign rom_tag_zero = (addr[ADDR_W-2:ROM_TAG_LO] == '0);
  assign addr_unused  = ^addr;

  always_comb begin
    if (!addr[ADDR_W-1])       region = REG_RAM;
    else if (rom_tag_zero)     region = REG_ROM;
    else                       region = REG_NONE;
  end

  always_comb begin
    lanes.ev_hi = !is_byte;
    lanes.od_lo = !is_byte || addr[0];
    lanes.ev_lo = is_byte && !addr[0];
    lanes.zr_hi = is_byte && !addr[0];
  end

  assign pair    = addr[PAIR_BIT];
  assign ram_idx = addr[RAM_IDX_W:1];
  assign rom_idx = addr[ROM_IDX_W:1];

endmodule

// File: rtl/mu_bank.sv
module mu_bank #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port, read-before-write: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rq <= mem[ra];
  end

endmodule

// File: rtl/mu_steer.sv
module mu_steer
  import mu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        vld,
  input  lanes_t      lanes,
  input  logic [7:0]  ev_byte,
  input  logic [7:0]  od_byte,
  output logic [15:0] rdata
);

  always_comb begin
    rdata = '0;
    if (vld) begin
      // zr_hi and "no lane" both leave the high half at zero
      if (lanes.ev_hi)      rdata[15:8] = ev_byte;
      if (lanes.od_lo)      rdata[7:0]  = od_byte;
      else if (lanes.ev_lo) rdata[7:0]  = ev_byte;
    end
  end

  // R5: byte reads never carry data on the high half
  p_byte_hi_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (vld && !lanes.ev_hi) |-> (rdata[15:8] == 8'h00));

  // R9: no drive while not valid
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !vld |-> (rdata == 16'h0000));

  // R5: the two even-bank paths never run together
  p_even_paths_excl_r5: assert property (@(posedge clk) disable iff (rst)
    vld |-> !(lanes.ev_hi && lanes.ev_lo));

endmodule

// File: rtl/split_lane_mem.sv
module split_lane_mem
  import mu_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int RAM_IDX_W  = 8,
  parameter int ROM_IDX_W  = 8,
  parameter int PAIR_BIT   = 20,
  parameter int ROM_TAG_LO = 17
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  rd,
  input  logic                  wr,
  input  logic                  is_byte,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output logic                  rvalid,
  input  logic                  ld_we,
  input  logic [ROM_TAG_LO-1:0] ld_addr,
  input  logic [7:0]            ld_data
);

  localparam int NPAIR = 2;
  localparam int BW    = DATA_W / 2;

  region_e              region;
  lanes_t               lanes;
  logic                 pair;
  logic [RAM_IDX_W-1:0] ram_idx;
  logic [ROM_IDX_W-1:0] rom_idx;

  mu_decode #(
    .ADDR_W(ADDR_W), .RAM_IDX_W(RAM_IDX_W), .ROM_IDX_W(ROM_IDX_W),
    .PAIR_BIT(PAIR_BIT), .ROM_TAG_LO(ROM_TAG_LO)
  ) i_decode (
    .addr(addr), .is_byte(is_byte), .region(region), .lanes(lanes),
    .pair(pair), .ram_idx(ram_idx), .rom_idx(rom_idx)
  );

  // ---------------- bus-side write steering ----------------
  logic [BW-1:0] ev_wd, od_wd;
  logic          ram_sel;

  assign ram_sel = (region == REG_RAM);
  assign ev_wd   = lanes.ev_hi ? wdata[DATA_W-1:BW] : wdata[BW-1:0];
  assign od_wd   = wdata[BW-1:0];

  // ---------------- RAM bank pairs ----------------
  logic [BW-1:0] ram_q [NPAIR][2];

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic hit;
    assign hit = ram_sel && (pair == p[0]);

    mu_bank #(.AW(RAM_IDX_W), .DW(BW)) i_even (
      .clk(clk), .we(wr && hit && (lanes.ev_hi || lanes.ev_lo)),
      .wa(ram_idx), .wd(ev_wd), .re(rd && hit), .ra(ram_idx),
      .rq(ram_q[p][0])
    );

    mu_bank #(.AW(RAM_IDX_W), .DW(BW)) i_odd (
      .clk(clk), .we(wr && hit && lanes.od_lo),
      .wa(ram_idx), .wd(od_wd), .re(rd && hit), .ra(ram_idx),
      .rq(ram_q[p][1])
    );
  end

  // ---------------- ROM shadow pair (loader writes only) ----------------
  logic [BW-1:0] rom_q [2];
  logic          ld_unused;

  assign ld_unused = ^ld_addr;

  for (genvar l = 0; l < 2; l++) begin : g_rom
    mu_bank #(.AW(ROM_IDX_W), .DW(BW)) i_rom (
      .clk(clk), .we(ld_we && (ld_addr[0] == l[0])),
      .wa(ld_addr[ROM_IDX_W:1]), .wd(ld_data),
      .re(rd && (region == REG_ROM)), .ra(rom_idx),
      .rq(rom_q[l])
    );
  end

  // ---------------- registered read context ----------------
  lanes_t  lanes_q;
  region_e region_q;
  logic    pair_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid   <= 1'b0;
      lanes_q  <= '0;
      region_q <= REG_NONE;
      pair_q   <= 1'b0;
    end else begin
      rvalid <= rd && (region != REG_NONE);
      if (rd) begin
        lanes_q  <= lanes;
        region_q <= region;
        pair_q   <= pair;
      end
    end
  end

  logic [BW-1:0] ev_byte, od_byte;

  always_comb begin
    if (region_q == REG_ROM) begin
      ev_byte = rom_q[0];
      od_byte = rom_q[1];
    end else begin
      ev_byte = ram_q[pair_q][0];
      od_byte = ram_q[pair_q][1];
    end
  end

  mu_steer i_steer (
    .clk(clk), .rst(rst), .vld(rvalid), .lanes(lanes_q),
    .ev_byte(ev_byte), .od_byte(od_byte), .rdata(rdata)
  );

  // R1: RAM reads are answered one cycle later
  p_ram_read_valid_r1: assert property (@(posedge clk) disable iff (rst)
    (rd && !addr[ADDR_W-1]) |=> rvalid);

  // R2: ROM-window reads are answered one cycle later
  p_rom_read_valid_r2: assert property (@(posedge clk) disable iff (rst)
    (rd && addr[ADDR_W-1] && (addr[ADDR_W-2:ROM_TAG_LO] == '0)) |=> rvalid);

  // R3: addresses outside both regions get no response
  p_dev_silent_r3: assert property (@(posedge clk) disable iff (rst)
    (rd && addr[ADDR_W-1] && (addr[ADDR_W-2:ROM_TAG_LO] != '0)) |=> !rvalid);

  // R9: no read strobe, no valid data next cycle
  p_no_read_no_valid_r9: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rvalid);

endmodule

// File: tb/test_split_lane_mem.sv
module test_split_lane_mem;

  localparam int RIW = 8;
  localparam int NIDX = 1 << RIW;

  logic        clk = 1'b0;
  logic        rst;
  logic [23:0] addr;
  logic        rd, wr, is_byte;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        rvalid;
  logic        ld_we;
  logic [16:0] ld_addr;
  logic [7:0]  ld_data;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // model: [pair][lane] for RAM, [lane] for ROM; lane 0 = even
  logic [7:0] m_ram [2][2][NIDX];
  logic [7:0] m_rom [2][NIDX];

  always #10 clk = ~clk;   // 50 MHz

  split_lane_mem #(.RAM_IDX_W(RIW), .ROM_IDX_W(RIW)) i_split_lane_mem (
    .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .is_byte(is_byte),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  function automatic int region_of(input logic [23:0] a);
    if (!a[23]) return 1;
    if (a[22:17] == 6'd0) return 2;
    return 0;
  endfunction

  function automatic logic [7:0] m_get(input logic [23:0] a, input int lane);
    if (region_of(a) == 1) return m_ram[a[20]][lane][a[RIW:1]];
    return m_rom[lane][a[RIW:1]];
  endfunction

  function automatic logic [15:0] exp_data(input logic [23:0] a, input logic b);
    if (region_of(a) == 0) return 16'h0000;
    if (!b) return {m_get(a, 0), m_get(a, 1)};
    return {8'h00, m_get(a, a[0] ? 1 : 0)};
  endfunction

  task automatic check(input string req, input logic [15:0] got_d, input logic got_v,
                       input logic [15:0] exp_d, input logic exp_v);
    checks++;
    if (got_d !== exp_d || got_v !== exp_v) begin
      errors++;
      $display("FAIL %s: actual rvalid=%0b rdata=%h, expected rvalid=%0b rdata=%h",
               req, got_v, got_d, exp_v, exp_d);
    end
  endtask

  task automatic bus_write(input logic [23:0] a, input logic b, input logic [15:0] d);
    @(negedge clk);
    addr = a; is_byte = b; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (region_of(a) == 1) begin
      if (!b) begin
        m_ram[a[20]][0][a[RIW:1]] = d[15:8];
        m_ram[a[20]][1][a[RIW:1]] = d[7:0];
      end else begin
        m_ram[a[20]][a[0] ? 1 : 0][a[RIW:1]] = d[7:0];
      end
    end
  endtask

  task automatic loader(input logic [16:0] la, input logic [7:0] d);
    @(negedge clk);
    ld_addr = la; ld_data = d; ld_we = 1'b1;
    @(negedge clk);
    ld_we = 1'b0;
    m_rom[la[0] ? 1 : 0][la[RIW:1]] = d;
  endtask

  // read with optional loader write in the same cycle
  task automatic bus_read(input string req, input logic [23:0] a, input logic b,
                          input bit with_ld, input logic [16:0] la, input logic [7:0] ld);
    logic [15:0] ed;
    logic        ev;
    @(negedge clk);
    addr = a; is_byte = b; rd = 1'b1;
    if (with_ld) begin ld_addr = la; ld_data = ld; ld_we = 1'b1; end
    ed = exp_data(a, b);
    ev = (region_of(a) != 0);
    @(negedge clk);
    rd = 1'b0; ld_we = 1'b0;
    check(req, rdata, rvalid, ed, ev);
    if (with_ld) m_rom[la[0] ? 1 : 0][la[RIW:1]] = ld;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_use;
    seed_use = $urandom(32'd2024);
    rst = 1'b1; rd = 1'b0; wr = 1'b0; is_byte = 1'b0; addr = '0; wdata = '0;
    ld_we = 1'b0; ld_addr = '0; ld_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R13: reset state
    check("R13 reset", rdata, rvalid, 16'h0000, 1'b0);

    // preload every location
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < NIDX; i++)
        bus_write({3'b000, p[0], 11'd0, i[7:0], 1'b0}, 1'b0, 16'($urandom));
    for (int i = 0; i < 2 * NIDX; i++)
      loader(17'(i), 8'($urandom));

    // R4 / R5 / R1: big-endian word and zero-filled bytes
    bus_write(24'h000006, 1'b0, 16'h576F);
    bus_read("R4 word read", 24'h000006, 1'b0, 0, '0, '0);
    check("R4 word value", rdata, 1'b1, 16'h576F, 1'b1);
    bus_read("R5 byte even", 24'h000006, 1'b1, 0, '0, '0);
    check("R5 byte even value", rdata, 1'b1, 16'h0057, 1'b1);
    bus_read("R5 byte odd", 24'h000007, 1'b1, 0, '0, '0);
    check("R5 byte odd value", rdata, 1'b1, 16'h006F, 1'b1);

    // R6: byte write keeps the neighbour byte
    bus_write(24'h000007, 1'b1, 16'hEEAB);
    bus_read("R6 byte write", 24'h000006, 1'b0, 0, '0, '0);
    check("R6 merged value", rdata, 1'b1, 16'h57AB, 1'b1);
    bus_write(24'h000006, 1'b1, 16'h11C3);
    bus_read("R6 even byte write", 24'h000006, 1'b0, 0, '0, '0);
    check("R6 even merged value", rdata, 1'b1, 16'hC3AB, 1'b1);

    // R7: pair select and aliasing
    bus_write(24'h100006, 1'b0, 16'h1234);
    bus_read("R7 other pair untouched", 24'h000006, 1'b0, 0, '0, '0);
    bus_read("R7 alias high bits", 24'h700006, 1'b0, 0, '0, '0);
    check("R7 alias value", rdata, 1'b1, 16'h1234, 1'b1);

    // R8: unaligned word
    bus_read("R8 odd word read", 24'h000007, 1'b0, 0, '0, '0);
    check("R8 odd word value", rdata, 1'b1, 16'hC3AB, 1'b1);
    bus_write(24'h100007, 1'b0, 16'hCAFE);
    bus_read("R8 odd word write", 24'h100006, 1'b0, 0, '0, '0);

    // R11 / R2: loader then bus read
    loader(17'h00010, 8'h5A);
    loader(17'h00011, 8'hA5);
    bus_read("R11 loader data", 24'h800010, 1'b0, 0, '0, '0);
    check("R11 loader value", rdata, 1'b1, 16'h5AA5, 1'b1);
    bus_read("R2 top of ROM", 24'h81FFFF, 1'b1, 0, '0, '0);

    // R10: bus write to ROM ignored
    bus_write(24'h800010, 1'b0, 16'hFFFF);
    bus_read("R10 ROM write ignored", 24'h800010, 1'b0, 0, '0, '0);
    check("R10 ROM value", rdata, 1'b1, 16'h5AA5, 1'b1);

    // R3: no response outside the regions, writes have no effect
    bus_read("R3 device read", 24'h900000, 1'b0, 0, '0, '0);
    bus_read("R3 gap read", 24'h820000, 1'b1, 0, '0, '0);
    bus_write(24'h900010, 1'b0, 16'h1111);
    bus_write(24'h820010, 1'b0, 16'h2222);
    bus_read("R3 ROM after device write", 24'h800010, 1'b0, 0, '0, '0);
    @(negedge clk);
    check("R9 idle after read", rdata, rvalid, 16'h0000, 1'b0);

    // R12: same-cycle loader write and bus read
    bus_read("R12 old value on collision", 24'h800010, 1'b0, 1, 17'h00010, 8'h3C);
    check("R12 old value", rdata, 1'b1, 16'h5AA5, 1'b1);
    bus_read("R12 new value after", 24'h800010, 1'b0, 0, '0, '0);
    check("R12 new value", rdata, 1'b1, 16'h3CA5, 1'b1);

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [23:0] a;
      logic        b;
      int          kind;
      a = 24'($urandom);
      kind = $urandom_range(99);
      if (kind < 60)      a[23] = 1'b0;
      else if (kind < 85) begin a[23] = 1'b1; a[22:17] = 6'd0; end
      else begin a[23] = 1'b1; if (a[22:17] == 6'd0) a[22] = 1'b1; end
      b = 1'($urandom);
      if ($urandom_range(1) == 0)
        bus_write(a, b, 16'($urandom));
      else if (region_of(a) == 2 && $urandom_range(3) == 0)
        bus_read("R12 random collision", a, b, 1, {a[16:1], 1'($urandom)}, 8'($urandom));
      else
        bus_read("R1 R2 R3 R4 R5 random read", a, b, 0, '0, '0);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule